// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns processor virtual addresses into physical addresses through a one-level page map kept in on-chip RAM. A virtual address splits into a page index (upper bits) and an in-page offset (lower bits). The page index selects one map entry directly. The offset is carried through unchanged, and the physical page number from the entry is placed above it. Each lookup also checks the entry's present flag and its permission flags against the access type and the privilege mode. It reports either a translated address, a missing-page fault or a protection fault. The two faults are never reported together.

On every successful access the unit writes the entry back to the map with its accessed flag set, and with its dirty flag set when the access was a write. Software reads these flags to pick victims for replacement and to find pages that must be written out. A configuration port lets software write a whole entry and read one back. After reset the unit sweeps the whole map to clear it, and it accepts no work until the sweep has finished.

The page size is a parameter. Larger pages shorten the page index and shrink the map.

Top module: `page_xlate`

## Requirements
- R1: The page index is `tr_vaddr[VA_W-1:PAGE_BITS]`. A translated address is `{entry physical page number, tr_vaddr[PAGE_BITS-1:0]}`.
- R2: If the present flag (entry bit 0) is clear, the result has `res_pfault`=1, `res_pviol`=0, `res_paddr`=0 and `res_cache`=0, whatever the permission flags say.
- R3: The permission flags are bit 1 (user read), bit 2 (user write), bit 3 (supervisor read) and bit 4 (supervisor write). If the entry is present but the flag for this mode and access type is clear, the result has `res_pviol`=1, `res_pfault`=0, `res_paddr`=0 and `res_cache`=0. The entry is left unchanged.
- R4: A successful read or write sets the accessed flag (bit 5) in the stored entry. A faulting access leaves the entry unchanged.
- R5: A successful write sets the dirty flag (bit 6). A successful read leaves the dirty flag as it was.
- R6: On success, `res_cache` equals the entry's cacheable flag (bit 7).
- R7: `res_valid` is a one-cycle pulse two cycles after the cycle in which `tr_valid && tr_ready`. `tr_ready` is low in the cycle after an acceptance. A translation accepted after a result sees the status update from that result.
- R8: A configuration write (`cfg_en`=1, `cfg_we`=1) stores `cfg_wdata` at `cfg_idx`. A configuration read (`cfg_en`=1, `cfg_we`=0) returns the entry on `cfg_rdata` with `cfg_rvalid`=1 in the next cycle. The entry layout is flags in bits 7:0 and the physical page number in bits `PPN_W+7:8`.
- R9: If a configuration write lands in the same cycle as a status write-back, a write to the same entry wins and the status update is dropped. A write to a different entry keeps both updates.
- R10: After reset the unit writes an all-zero entry to every index. Until that is done, `tr_ready` stays low and configuration accesses are ignored (`cfg_rvalid` stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tr_valid | input | 1 | Translation request valid |
| tr_ready | output | 1 | Translation request can be accepted |
| tr_vaddr | input | VA_W | Virtual address |
| tr_write | input | 1 | 1 = write access, 0 = read access |
| tr_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| res_valid | output | 1 | Result pulse |
| res_paddr | output | PA_W | Physical address, zero on a fault |
| res_cache | output | 1 | Cacheable flag of the translated page |
| res_pfault | output | 1 | Page not present |
| res_pviol | output | 1 | Permission violation |
| cfg_en | input | 1 | Configuration access strobe |
| cfg_we | input | 1 | 1 = write entry, 0 = read entry |
| cfg_idx | input | VA_W-PAGE_BITS | Entry index |
| cfg_wdata | input | PPN_W+8 | Entry to write |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rdata | output | PPN_W+8 | Entry read back |

## Verification
The bench keeps its own model of the map and goes after the cases where the status bits and the faults meet. An entry that is not present but has all its permission flags set must give a missing-page fault only; a design that checks permissions first would report a protection fault there. A write that is refused must leave the dirty and accessed flags clear, and a read must not set dirty; a design that writes back before checking would show set flags when the entry is read back. A configuration write timed to meet a write-back, once to the same entry and once to another, shows whether the design loses the neighbour's status update or lets a stale write-back overwrite the new software entry. The first and last map indices with an all-ones offset show a design that cuts or shifts the page-number field.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;
  // entry flag positions; the physical page number sits above them
  localparam int F_PRES  = 0;
  localparam int F_UR    = 1;
  localparam int F_UW    = 2;
  localparam int F_SR    = 3;
  localparam int F_SW    = 4;
  localparam int F_ACC   = 5;
  localparam int F_DIRTY = 6;
  localparam int F_CACHE = 7;
  localparam int N_FLAGS = 8;
endpackage

// File: rtl/pxl_ram.sv
module pxl_ram #(
  parameter int AW = 11,
  parameter int DW = 20
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pxl_sweep.sv
module pxl_sweep #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  output logic          we,
  output logic [AW-1:0] idx,
  output logic          done
);
  logic [AW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (&cnt) done <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end

  assign we  = !done;
  assign idx = cnt;
endmodule

// File: rtl/pxl_check.sv
module pxl_check
  import page_xlate_pkg::*;
#(
  parameter int PPN_W = 12,
  localparam int ENT_W = PPN_W + N_FLAGS
) (
  input  logic [ENT_W-1:0] entry,
  input  logic             is_wr,
  input  logic             is_sup,
  output logic             ok,
  output logic             miss,
  output logic             deny,
  output logic [PPN_W-1:0] ppn,
  output logic             cch,
  output logic [ENT_W-1:0] upd
);
  logic allow;

  always_comb begin
    if (is_sup) allow = is_wr ? entry[F_SW] : entry[F_SR];
    else        allow = is_wr ? entry[F_UW] : entry[F_UR];
    miss = !entry[F_PRES];
    deny = entry[F_PRES] && !allow;
    ok   = entry[F_PRES] && allow;
    upd  = entry;
    upd[F_ACC] = 1'b1;
    if (is_wr) upd[F_DIRTY] = 1'b1;
  end

  assign ppn = entry[N_FLAGS +: PPN_W];
  assign cch = entry[F_CACHE];
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import page_xlate_pkg::*;
#(
  parameter int VA_W      = 24,
  parameter int PAGE_BITS = 13,
  parameter int PPN_W     = 12,
  localparam int VPN_W = VA_W - PAGE_BITS,
  localparam int PA_W  = PPN_W + PAGE_BITS,
  localparam int ENT_W = PPN_W + N_FLAGS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tr_valid,
  output logic             tr_ready,
  input  logic [VA_W-1:0]  tr_vaddr,
  input  logic             tr_write,
  input  logic             tr_super,
  output logic             res_valid,
  output logic [PA_W-1:0]  res_paddr,
  output logic             res_cache,
  output logic             res_pfault,
  output logic             res_pviol,
  input  logic             cfg_en,
  input  logic             cfg_we,
  input  logic [VPN_W-1:0] cfg_idx,
  input  logic [ENT_W-1:0] cfg_wdata,
  output logic             cfg_rvalid,
  output logic [ENT_W-1:0] cfg_rdata
);
  // initialisation sweep
  logic             sweep_we, sweep_done;
  logic [VPN_W-1:0] sweep_idx;

  pxl_sweep #(.AW(VPN_W)) u_sweep (
    .clk(clk), .rst(rst), .we(sweep_we), .idx(sweep_idx), .done(sweep_done)
  );

  // request side
  logic             s1_vld, s1_wr, s1_sup;
  logic [VPN_W-1:0] s1_vpn;
  logic [PAGE_BITS-1:0] s1_off;
  logic             pend_vld;
  logic [VPN_W-1:0] pend_idx;
  logic [ENT_W-1:0] pend_dat;

  logic cfg_rd, cfg_wr, accept;
  logic [VPN_W-1:0] tr_vpn;

  assign tr_vpn   = tr_vaddr[VA_W-1:PAGE_BITS];
  assign cfg_rd   = sweep_done && cfg_en && !cfg_we;
  assign cfg_wr   = sweep_done && cfg_en && cfg_we;
  assign tr_ready = sweep_done && !s1_vld && !pend_vld && !cfg_en;
  assign accept   = tr_valid && tr_ready;

  // map storage
  logic             mem_we;
  logic [VPN_W-1:0] mem_waddr, mem_raddr;
  logic [ENT_W-1:0] mem_wdata, mem_q;

  pxl_ram #(.AW(VPN_W), .DW(ENT_W)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_q)
  );

  assign mem_raddr = cfg_rd ? cfg_idx : tr_vpn;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
    end else begin
      s1_vld <= accept;
    end
    if (accept) begin
      s1_vpn <= tr_vpn;
      s1_off <= tr_vaddr[PAGE_BITS-1:0];
      s1_wr  <= tr_write;
      s1_sup <= tr_super;
    end
  end

  // entry check
  logic             chk_ok, chk_miss, chk_deny, chk_cch;
  logic [PPN_W-1:0] chk_ppn;
  logic [ENT_W-1:0] chk_upd;

  pxl_check #(.PPN_W(PPN_W)) u_check (
    .entry(mem_q), .is_wr(s1_wr), .is_sup(s1_sup),
    .ok(chk_ok), .miss(chk_miss), .deny(chk_deny),
    .ppn(chk_ppn), .cch(chk_cch), .upd(chk_upd)
  );

  // status write-back, software writes take the port first
  logic             wb_now, wb_vld;
  logic [VPN_W-1:0] wb_idx;
  logic [ENT_W-1:0] wb_dat;

  assign wb_now = s1_vld && chk_ok;
  assign wb_vld = pend_vld || wb_now;
  assign wb_idx = pend_vld ? pend_idx : s1_vpn;
  assign wb_dat = pend_vld ? pend_dat : chk_upd;

  always_comb begin
    mem_we    = sweep_we || cfg_wr || wb_vld;
    mem_waddr = wb_idx;
    mem_wdata = wb_dat;
    if (sweep_we) begin
      mem_waddr = sweep_idx;
      mem_wdata = '0;
    end else if (cfg_wr) begin
      mem_waddr = cfg_idx;
      mem_wdata = cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_vld <= 1'b0;
    else     pend_vld <= wb_vld && cfg_wr && (cfg_idx != wb_idx);
    pend_idx <= wb_idx;
    pend_dat <= wb_dat;
  end

  // registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_paddr  <= '0;
      res_cache  <= 1'b0;
      res_pfault <= 1'b0;
      res_pviol  <= 1'b0;
      cfg_rvalid <= 1'b0;
    end else begin
      res_valid  <= s1_vld;
      cfg_rvalid <= cfg_rd;
      if (s1_vld) begin
        res_pfault <= chk_miss;
        res_pviol  <= chk_deny;
        res_cache  <= chk_ok && chk_cch;
        res_paddr  <= chk_ok ? {chk_ppn, s1_off} : '0;
      end
    end
  end

  assign cfg_rdata = mem_q;
endmodule

// File: rtl/pxl_props.sv
module pxl_props #(
  parameter int VA_W      = 24,
  parameter int PAGE_BITS = 13,
  parameter int PA_W      = 25
) (
  input logic            clk,
  input logic            rst,
  input logic            tr_valid,
  input logic            tr_ready,
  input logic [VA_W-1:0] tr_vaddr,
  input logic            res_valid,
  input logic [PA_W-1:0] res_paddr,
  input logic            res_cache,
  input logic            res_pfault,
  input logic            res_pviol,
  input logic            cfg_en,
  input logic            cfg_we,
  input logic            cfg_rvalid,
  input logic            sweep_done
);
  logic acc;
  assign acc = tr_valid && tr_ready;

  a_r7_resp_latency: assert property (@(posedge clk) disable iff (rst)
    acc |-> ##2 res_valid);
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(acc, 2));
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    acc |=> !tr_ready);
  a_r2_faults_exclusive: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !(res_pfault && res_pviol));
  a_r3_fault_zero_addr: assert property (@(posedge clk) disable iff (rst)
    (res_valid && (res_pfault || res_pviol)) |-> (res_paddr == '0 && !res_cache));
  a_r1_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_pfault && !res_pviol) |->
      res_paddr[PAGE_BITS-1:0] == $past(tr_vaddr[PAGE_BITS-1:0], 2));
  a_r8_read_reply: assert property (@(posedge clk) disable iff (rst)
    (sweep_done && cfg_en && !cfg_we) |=> cfg_rvalid);
  a_r10_idle_in_sweep: assert property (@(posedge clk) disable iff (rst)
    !sweep_done |-> !tr_ready);
endmodule

bind page_xlate pxl_props #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PA_W(PA_W)) u_props (
  .clk(clk), .rst(rst), .tr_valid(tr_valid), .tr_ready(tr_ready),
  .tr_vaddr(tr_vaddr), .res_valid(res_valid), .res_paddr(res_paddr),
  .res_cache(res_cache), .res_pfault(res_pfault), .res_pviol(res_pviol),
  .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_rvalid(cfg_rvalid),
  .sweep_done(sweep_done)
);

// File: tb/sim_page_xlate.sv
module sim_page_xlate;
  localparam int VA_W = 24, PAGE_BITS = 13, PPN_W = 12;
  localparam int VPN_W = VA_W - PAGE_BITS, PA_W = PPN_W + PAGE_BITS;
  localparam int ENT_W = PPN_W + 8, DEPTH = 1 << VPN_W;

  logic clk = 1'b0, rst = 1'b1;
  logic tr_valid = 1'b0, tr_write = 1'b0, tr_super = 1'b0;
  logic [VA_W-1:0] tr_vaddr = '0;
  logic tr_ready, res_valid, res_cache, res_pfault, res_pviol, cfg_rvalid;
  logic [PA_W-1:0] res_paddr;
  logic cfg_en = 1'b0, cfg_we = 1'b0;
  logic [VPN_W-1:0] cfg_idx = '0;
  logic [ENT_W-1:0] cfg_wdata = '0, cfg_rdata;

  always #10 clk = ~clk;

  page_xlate #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PPN_W(PPN_W)) u0 (.*);

  int n_run = 0, n_fail = 0;
  logic [ENT_W-1:0] shadow [int];
  logic [PA_W-1:0] q_pa [$];
  bit q_pf [$], q_pv [$], q_c [$];
  string q_tag [$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [ENT_W-1:0] model(int i);
    return shadow.exists(i) ? shadow[i] : '0;
  endfunction

  function automatic logic [ENT_W-1:0] mk(int ppn, logic [7:0] flags);
    return {ppn[PPN_W-1:0], flags};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (q_tag.size() == 0) begin
        check("R7 unexpected result", 32'd1, 32'd0);
      end else begin
        string t;
        t = q_tag.pop_front();
        check({t, " paddr"}, 32'(res_paddr), 32'(q_pa.pop_front()));
        check({t, " pfault"}, 32'(res_pfault), 32'(q_pf.pop_front()));
        check({t, " pviol"}, 32'(res_pviol), 32'(q_pv.pop_front()));
        check({t, " cache"}, 32'(res_cache), 32'(q_c.pop_front()));
      end
    end
  end

  // computes the expected result, pushes it and updates the model at acceptance
  function automatic logic [ENT_W-1:0] predict(logic [VA_W-1:0] va, bit wr, bit sup, string tag);
    int i;
    logic [ENT_W-1:0] e;
    bit allow;
    i = int'(va[VA_W-1:PAGE_BITS]);
    e = model(i);
    allow = sup ? (wr ? e[4] : e[3]) : (wr ? e[2] : e[1]);
    q_tag.push_back(tag);
    if (!e[0]) begin
      q_pa.push_back('0); q_pf.push_back(1); q_pv.push_back(0); q_c.push_back(0);
    end else if (!allow) begin
      q_pa.push_back('0); q_pf.push_back(0); q_pv.push_back(1); q_c.push_back(0);
    end else begin
      q_pa.push_back({e[ENT_W-1:8], va[PAGE_BITS-1:0]});
      q_pf.push_back(0); q_pv.push_back(0); q_c.push_back(e[7]);
      e[5] = 1'b1;
      if (wr) e[6] = 1'b1;
    end
    return e;
  endfunction

  task automatic translate(logic [VA_W-1:0] va, bit wr, bit sup, string tag);
    logic [ENT_W-1:0] e;
    @(negedge clk);
    tr_valid = 1'b1; tr_vaddr = va; tr_write = wr; tr_super = sup;
    while (!tr_ready) @(negedge clk);
    e = predict(va, wr, sup, tag);
    shadow[int'(va[VA_W-1:PAGE_BITS])] = e;
    @(posedge clk);
    #1 tr_valid = 1'b0;
  endtask

  task automatic cfg_write(int idx, logic [ENT_W-1:0] d);
    @(negedge clk);
    cfg_en = 1'b1; cfg_we = 1'b1; cfg_idx = VPN_W'(idx); cfg_wdata = d;
    shadow[idx] = d;
    @(posedge clk);
    #1 cfg_en = 1'b0;
  endtask

  task automatic cfg_read_check(int idx, string req);
    @(negedge clk);
    cfg_en = 1'b1; cfg_we = 1'b0; cfg_idx = VPN_W'(idx);
    @(posedge clk);
    #1 cfg_en = 1'b0;
    @(negedge clk);
    check({req, " rvalid"}, 32'(cfg_rvalid), 32'd1);
    check({req, " entry"}, 32'(cfg_rdata), 32'(model(idx)));
  endtask

  task automatic drain();
    repeat (6) @(negedge clk);
    check("R7 queue drained", 32'(q_tag.size()), 32'd0);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    logic [VA_W-1:0] va;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R10: during the sweep
    repeat (5) @(negedge clk);
    check("R10 ready low in sweep", 32'(tr_ready), 32'd0);
    cfg_en = 1'b1; cfg_we = 1'b0; cfg_idx = 3;
    @(negedge clk);
    cfg_en = 1'b0;
    @(negedge clk);
    check("R10 cfg ignored in sweep", 32'(cfg_rvalid), 32'd0);
    cyc = 7;
    while (!tr_ready && cyc < 5000) begin @(negedge clk); cyc++; end
    check("R10 sweep length", 32'(cyc >= DEPTH), 32'd1);
    check("R10 ready after sweep", 32'(tr_ready), 32'd1);
    cfg_read_check(DEPTH - 1, "R10 cleared last");
    cfg_read_check(0, "R10 cleared first");
    translate({VPN_W'(77), 13'h0042}, 0, 1, "R10 R2 unmapped");
    drain();

    // R8 write and read back; R1 R6 successful read
    cfg_write(5, mk('hABC, 8'b1000_1011)); // cache, sr, ur, present
    cfg_read_check(5, "R8 readback");
    translate({VPN_W'(5), 13'h0123}, 0, 0, "R1 R6 user read");
    drain();
    cfg_read_check(5, "R4 R5 accessed set dirty clear");
    translate({VPN_W'(5), 13'h0010}, 1, 0, "R3 user write denied");
    drain();
    cfg_read_check(5, "R3 entry unchanged");
    cfg_write(6, mk('h123, 8'b0001_1001)); // sw, sr, present, not cacheable
    translate({VPN_W'(6), 13'h1FFF}, 1, 1, "R5 R6 super write");
    drain();
    cfg_read_check(6, "R5 dirty set");
    cfg_write(7, mk('h0F0, 8'b0000_0001));
    translate({VPN_W'(7), 13'h0004}, 0, 1, "R3 no permission");
    cfg_write(8, mk('h0F1, 8'b1001_1110)); // all perms, not present
    translate({VPN_W'(8), 13'h0004}, 1, 1, "R2 absent wins");
    drain();
    cfg_read_check(8, "R4 fault leaves entry");

    // R1 boundaries
    cfg_write(0, mk('hFFF, 8'b0000_0011));
    cfg_write(DEPTH - 1, mk('h001, 8'b1000_0011));
    translate({VPN_W'(0), 13'h1FFF}, 0, 0, "R1 first index");
    translate({VPN_W'(DEPTH - 1), 13'h1FFF}, 0, 0, "R1 last index");
    drain();

    // R7 cycle timing and write-back visibility
    cfg_write(9, mk('h055, 8'b0001_1111));
    @(negedge clk);
    tr_valid = 1'b1; tr_vaddr = {VPN_W'(9), 13'h0777}; tr_write = 1'b1; tr_super = 1'b0;
    check("R7 ready before accept", 32'(tr_ready), 32'd1);
    shadow[9] = predict(tr_vaddr, 1, 0, "R7 timed write");
    @(posedge clk);
    #1 tr_valid = 1'b0;
    @(negedge clk);
    check("R7 no result one cycle on", 32'(res_valid), 32'd0);
    check("R7 busy after accept", 32'(tr_ready), 32'd0);
    @(negedge clk);
    check("R7 result two cycles on", 32'(res_valid), 32'd1);
    translate({VPN_W'(9), 13'h0001}, 0, 1, "R7 follow-up");
    drain();
    cfg_read_check(9, "R7 status committed");

    // R9 software write meets write-back
    for (int k = 0; k < 2; k++) begin
      int other;
      other = (k == 0) ? 10 : 11;
      cfg_write(10, mk('h0AA, 8'b0000_0011));
      @(negedge clk);
      va = {VPN_W'(10), 13'h0020};
      tr_valid = 1'b1; tr_vaddr = va; tr_write = 1'b0; tr_super = 1'b0;
      while (!tr_ready) @(negedge clk);
      shadow[10] = predict(va, 0, 0, "R9 collide");
      @(posedge clk);
      #1 tr_valid = 1'b0;
      @(negedge clk);
      cfg_en = 1'b1; cfg_we = 1'b1; cfg_idx = VPN_W'(other);
      cfg_wdata = mk('h0BB + k, 8'b0000_1001);
      shadow[other] = cfg_wdata;
      @(posedge clk);
      #1 cfg_en = 1'b0;
      drain();
      cfg_read_check(10, (k == 0) ? "R9 same entry sw wins" : "R9 other entry status kept");
      cfg_read_check(other, "R9 sw entry stored");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule